// File: doc/BRIEF.md
# Odd-only prime sieve engine

This block finds the odd primes above 2 by crossing out composites in a one-bit flag table. Table entry `j` stands for the odd value `2j+3`, so even numbers take no storage. After reset, or after a start pulse once a run has finished, the engine writes a 1 into every entry. It then walks the table from index 0 upward. Each entry still set when reached is counted as a prime, and every later odd multiple of its value is cleared.

A free-running counter records how many clock cycles the run has taken, including the fill phase. It stops when the walk ends and the `done` flag rises. While `done` is high, the finished table can be read one entry at a time through a peek port. Data comes back one cycle after the address is applied. The flags and the prime count then give the primes from 3 up to `2*DEPTH+1`.

The table is a synchronous single-port RAM. The sweep index and the elimination pointer share its one address input, and a single adder produces both the first elimination index and each step.

Top module: `prime_sieve_engine`

## Requirements
- R1: While reset is applied, `done` is 0, `prime_count` is 0 and `cycle_count` is 0. When reset is released, a run begins by itself.
- R2: Each run opens with a fill phase of exactly DEPTH cycles that writes 1 into every flag entry. Entry j represents the odd value 2j+3, and a flag of 1 means "still a candidate".
- R3: The sweep visits each index j from 0 to DEPTH-1 in turn. When the flag of j reads 1, `prime_count` grows by one. When it reads 0, j advances with no other effect.
- R4: For a surviving entry j, the engine clears entry 3j+3, then every entry a further 2j+3 on, and stops at the first index that is DEPTH or more. Entries of composite values (for example entry 3, value 9) end at 0, and entries of primes (for example entry 4, value 11) end at 1.
- R5: With the default DEPTH of 1024, a finished run reports `prime_count` = 308.
- R6: `cycle_count` grows by one on every clock edge from the start of the run until `done` rises. Its final value is DEPTH + 1 + the sum over all j of 3 when entry j is 0, or 5 + 2n when it survives, where n is the number of indices it clears.
- R7: `done` stays high until the next start pulse or reset. While it is high, `prime_count` and `cycle_count` do not change.
- R8: A start pulse while the run is in progress (done = 0) is ignored. The run ends with the same counts as an undisturbed run.
- R9: A start pulse while `done` is high clears both counters and `done` on the next edge, then runs the fill and sweep again.
- R10: While `done` is high, `peek_flag` shows the flag of entry `peek_addr` one clock cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle pulse that launches a new run when done is high |
| peek_addr | input | $clog2(DEPTH) | Flag entry to inspect while done is high |
| done | output | 1 | High once the sweep has finished |
| prime_count | output | PCNT_W | Number of primes found |
| cycle_count | output | CCNT_W | Clock cycles used by the run, frozen at done |
| peek_flag | output | 1 | Flag of the inspected entry, one cycle after peek_addr |

## Verification
The bench checks the small indices where crossing-out first starts (entry 3 cleared by the first prime, entry 4 kept) and the last table entry. A wrong first elimination index or step clears primes or keeps composites, and the flags and prime count show it. It compares the exact cycle count with a model of the state sequence, so an extra or missing wait state, or a fill length off by one, moves the figure. It pulses start in the middle of a run; a design that restarts on it would finish with a larger cycle count. It also samples the counters after done to catch a cycle counter that keeps running.

// File: rtl/sieve_pkg.sv
package sieve_pkg;

  typedef enum logic [3:0] {
    ST_FILL  = 4'd0,  // write 1 into every flag
    ST_JCHK  = 4'd1,  // bound test on j, present j to the RAM
    ST_FLAG  = 4'd2,  // registered flag of j is valid here
    ST_SKIP  = 4'd3,  // return after a cleared entry
    ST_BLOAD = 4'd4,  // b <= a + j
    ST_BCHK  = 4'd5,  // bound test on b, clear and step
    ST_STEP  = 4'd6,  // return into the clear loop
    ST_NEXTJ = 4'd7,  // return after the clear loop
    ST_DONE  = 4'd8   // terminal, holds until start
  } sv_state_e;

  typedef struct packed {
    logic j_clr;
    logic j_inc;
    logic a_ld;
    logic b_ld;
    logic sel_j;     // 1: j drives adder and address, 0: b does
    logic ram_we;
    logic ram_wd;
    logic p_clr;
    logic p_inc;
    logic c_clr;
    logic c_inc;
    logic peek_mode; // RAM address taken from the peek port
  } sv_ctl_t;

endpackage

// File: rtl/sieve_rst_sync.sv
module sieve_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;

endmodule

// File: rtl/sieve_flag_ram.sv
module sieve_flag_ram #(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic          wd,
  output logic          rd
);

  logic mem [DEPTH];
  logic rd_q;

  // single port, registered read, one cycle latency
  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wd;
    end
    rd_q <= mem[addr];
  end

  assign rd = rd_q;

endmodule

// File: rtl/sieve_datapath.sv
module sieve_datapath
  import sieve_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int PCNT_W = 16,
  parameter int CCNT_W = 20,
  localparam int AW    = $clog2(DEPTH),
  localparam int IDX_W = AW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sv_ctl_t           ctl,
  input  logic [AW-1:0]     peek_addr,
  output logic              j_lt,
  output logic              b_lt,
  output logic              fill_last,
  output logic [AW-1:0]     ram_addr,
  output logic [PCNT_W-1:0] prime_count,
  output logic [CCNT_W-1:0] cycle_count
);

  localparam logic [IDX_W-1:0] DEPTH_I = IDX_W'(DEPTH);
  localparam logic [IDX_W-1:0] LAST_I  = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0]  j_q, j_d;
  logic [IDX_W-1:0]  a_q, a_d;
  logic [IDX_W-1:0]  b_q, b_d;
  logic [IDX_W-1:0]  k;
  logic [IDX_W-1:0]  sum;
  logic [PCNT_W-1:0] p_q, p_d;
  logic [CCNT_W-1:0] c_q, c_d;

  // shared operand select and single adder
  assign k   = ctl.sel_j ? j_q : b_q;
  assign sum = k + a_q;

  always_comb begin
    j_d = j_q;
    if (ctl.j_clr) begin
      j_d = '0;
    end else if (ctl.j_inc) begin
      j_d = j_q + IDX_W'(1);
    end
  end

  always_comb begin
    a_d = a_q;
    if (ctl.a_ld) begin
      a_d = {j_q[IDX_W-2:0], 1'b0} + IDX_W'(3);
    end
  end

  always_comb begin
    b_d = b_q;
    if (ctl.b_ld) begin
      b_d = sum;
    end
  end

  always_comb begin
    p_d = p_q;
    if (ctl.p_clr) begin
      p_d = '0;
    end else if (ctl.p_inc) begin
      p_d = p_q + PCNT_W'(1);
    end
  end

  always_comb begin
    c_d = c_q;
    if (ctl.c_clr) begin
      c_d = '0;
    end else if (ctl.c_inc) begin
      c_d = c_q + CCNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      j_q <= '0;
      a_q <= '0;
      b_q <= '0;
      p_q <= '0;
      c_q <= '0;
    end else begin
      j_q <= j_d;
      a_q <= a_d;
      b_q <= b_d;
      p_q <= p_d;
      c_q <= c_d;
    end
  end

  assign j_lt        = (j_q < DEPTH_I);
  assign b_lt        = (b_q < DEPTH_I);
  assign fill_last   = (j_q == LAST_I);
  assign ram_addr    = ctl.peek_mode ? peek_addr : k[AW-1:0];
  assign prime_count = p_q;
  assign cycle_count = c_q;

  // R6: an enabled count step moves the counter by exactly one
  a_r6_cycle_step : assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.c_inc && !ctl.c_clr) |=> (c_q == $past(c_q) + CCNT_W'(1)));

  // R4: a clearing write never targets an index outside the table
  a_r4_clear_in_range : assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.ram_we && !ctl.ram_wd) |-> (b_q < DEPTH_I));

  // R3: the sweep index never runs past the table end
  a_r3_j_bound : assert property (@(posedge clk) disable iff (!rst_n)
    (j_q <= DEPTH_I));

endmodule

// File: rtl/sieve_ctrl.sv
module sieve_ctrl
  import sieve_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    j_lt,
  input  logic    b_lt,
  input  logic    fill_last,
  input  logic    flag,
  output sv_ctl_t ctl,
  output logic    done
);

  sv_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    ctl  = '0;
    unique case (st_q)
      ST_FILL: begin
        ctl.sel_j  = 1'b1;
        ctl.ram_we = 1'b1;
        ctl.ram_wd = 1'b1;
        ctl.c_inc  = 1'b1;
        if (fill_last) begin
          ctl.j_clr = 1'b1;
          st_d      = ST_JCHK;
        end else begin
          ctl.j_inc = 1'b1;
        end
      end
      ST_JCHK: begin
        ctl.sel_j = 1'b1;
        ctl.c_inc = 1'b1;
        st_d      = j_lt ? ST_FLAG : ST_DONE;
      end
      ST_FLAG: begin
        ctl.sel_j = 1'b1;
        ctl.c_inc = 1'b1;
        if (flag) begin
          ctl.p_inc = 1'b1;
          ctl.a_ld  = 1'b1;
          st_d      = ST_BLOAD;
        end else begin
          ctl.j_inc = 1'b1;
          st_d      = ST_SKIP;
        end
      end
      ST_SKIP: begin
        ctl.c_inc = 1'b1;
        st_d      = ST_JCHK;
      end
      ST_BLOAD: begin
        ctl.sel_j = 1'b1;
        ctl.b_ld  = 1'b1;
        ctl.c_inc = 1'b1;
        st_d      = ST_BCHK;
      end
      ST_BCHK: begin
        ctl.c_inc = 1'b1;
        if (b_lt) begin
          ctl.ram_we = 1'b1;
          ctl.ram_wd = 1'b0;
          ctl.b_ld   = 1'b1;
          st_d       = ST_STEP;
        end else begin
          ctl.j_inc = 1'b1;
          st_d      = ST_NEXTJ;
        end
      end
      ST_STEP: begin
        ctl.c_inc = 1'b1;
        st_d      = ST_BCHK;
      end
      ST_NEXTJ: begin
        ctl.c_inc = 1'b1;
        st_d      = ST_JCHK;
      end
      ST_DONE: begin
        ctl.peek_mode = 1'b1;
        if (start) begin
          ctl.j_clr = 1'b1;
          ctl.p_clr = 1'b1;
          ctl.c_clr = 1'b1;
          st_d      = ST_FILL;
        end
      end
      default: begin
        st_d = ST_DONE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_FILL;
    end else begin
      st_q <= st_d;
    end
  end

  assign done = (st_q == ST_DONE);

  // R7: the terminal state is left only on a start pulse
  a_r7_done_sticky : assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE && !start) |=> (st_q == ST_DONE));

  // R8: once sweeping, no path leads back into the fill phase
  a_r8_no_restart_busy : assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_DONE && st_q != ST_FILL) |=> (st_q != ST_FILL));

  // R2: the fill phase is left only toward the sweep
  a_r2_fill_exit : assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FILL) |=> (st_q == ST_FILL || st_q == ST_JCHK));

endmodule

// File: rtl/prime_sieve_engine.sv
module prime_sieve_engine
  import sieve_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int PCNT_W = 16,
  parameter int CCNT_W = 20,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     peek_addr,
  output logic              done,
  output logic [PCNT_W-1:0] prime_count,
  output logic [CCNT_W-1:0] cycle_count,
  output logic              peek_flag
);

  logic          rst_n_s;
  sv_ctl_t       ctl;
  logic          j_lt;
  logic          b_lt;
  logic          fill_last;
  logic [AW-1:0] ram_addr;
  logic          flag_rd;

  sieve_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  sieve_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start     (start),
    .j_lt      (j_lt),
    .b_lt      (b_lt),
    .fill_last (fill_last),
    .flag      (flag_rd),
    .ctl       (ctl),
    .done      (done)
  );

  sieve_datapath #(
    .DEPTH  (DEPTH),
    .PCNT_W (PCNT_W),
    .CCNT_W (CCNT_W)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .ctl         (ctl),
    .peek_addr   (peek_addr),
    .j_lt        (j_lt),
    .b_lt        (b_lt),
    .fill_last   (fill_last),
    .ram_addr    (ram_addr),
    .prime_count (prime_count),
    .cycle_count (cycle_count)
  );

  sieve_flag_ram #(
    .DEPTH (DEPTH)
  ) u_ram (
    .clk  (clk),
    .addr (ram_addr),
    .we   (ctl.ram_we),
    .wd   (ctl.ram_wd),
    .rd   (flag_rd)
  );

  assign peek_flag = flag_rd;

  // R7: outputs hold still while done and no restart is requested
  a_r7_outputs_frozen : assert property (@(posedge clk) disable iff (!rst_n_s)
    (done && !start) |=> ($stable(prime_count) && $stable(cycle_count)));

  // R9: a start seen while done restarts with cleared counters
  a_r9_restart_clears : assert property (@(posedge clk) disable iff (!rst_n_s)
    (done && start) |=> (!done && prime_count == '0 && cycle_count == '0));

  // R1: in reset, the counters read zero
  a_r1_reset_zero : assert property (@(posedge clk)
    (!rst_n_s) |-> (prime_count == '0 && cycle_count == '0 && !done));

endmodule

// File: tb/tb_prime_sieve_engine.sv
module tb_prime_sieve_engine;

  localparam int DEPTH  = 1024;
  localparam int AW     = $clog2(DEPTH);
  localparam int PCNT_W = 16;
  localparam int CCNT_W = 20;

  logic              clk;
  logic              rst_n;
  logic              start;
  logic [AW-1:0]     peek_addr;
  logic              done;
  logic [PCNT_W-1:0] prime_count;
  logic [CCNT_W-1:0] cycle_count;
  logic              peek_flag;

  prime_sieve_engine #(
    .DEPTH  (DEPTH),
    .PCNT_W (PCNT_W),
    .CCNT_W (CCNT_W)
  ) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .peek_addr   (peek_addr),
    .done        (done),
    .prime_count (prime_count),
    .cycle_count (cycle_count),
    .peek_flag   (peek_flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk;
  int n_bad;

  // model results
  bit model_flag [DEPTH];
  int model_primes;
  int model_cycles;

  typedef struct {
    int idx;
    bit exp;
  } peek_item_t;

  peek_item_t exp_q [$];

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic build_model();
    model_primes = 0;
    model_cycles = DEPTH + 1;
    for (int i = 0; i < DEPTH; i++) model_flag[i] = 1'b1;
    for (int j = 0; j < DEPTH; j++) begin
      if (model_flag[j]) begin
        int a;
        int b;
        int n;
        model_primes++;
        a = 2 * j + 3;
        b = a + j;
        n = 0;
        while (b < DEPTH) begin
          model_flag[b] = 1'b0;
          b = b + a;
          n++;
        end
        model_cycles += 5 + 2 * n;
      end else begin
        model_cycles += 3;
      end
    end
  endtask

  // driver: present an address, push expected flag (R10)
  task automatic peek(int idx);
    @(negedge clk);
    peek_addr = idx[AW-1:0];
    exp_q.push_back('{idx, model_flag[idx]});
  endtask

  // monitor: data of the address pushed on the previous negedge
  peek_item_t mon_it;
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      mon_it = exp_q.pop_front();
      n_chk++;
      if (peek_flag !== mon_it.exp) begin
        n_bad++;
        $display("FAIL R10/R4 flag entry %0d (value %0d) actual=%0d expected=%0d",
                 mon_it.idx, 2 * mon_it.idx + 3, peek_flag, mon_it.exp);
      end
    end
  end

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int c = 0; c < 60000; c++) begin
      @(negedge clk);
      if (done) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1500000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    finish_run();
  end

  initial begin
    bit ok;
    n_chk = 0;
    n_bad = 0;
    build_model();
    chk("R5 model count", model_primes, 308);

    rst_n     = 1'b0;
    start     = 1'b0;
    peek_addr = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 done in reset", done, 0);
    chk("R1 prime_count in reset", prime_count, 0);
    chk("R1 cycle_count in reset", cycle_count, 0);
    rst_n = 1'b1;

    wait_done(ok);
    chk("R1 run completes after reset", ok, 1);
    if (!ok) finish_run();
    chk("R3 R5 prime count run 1", prime_count, model_primes);
    chk("R5 prime count equals 308", prime_count, 308);
    chk("R6 R2 cycle count run 1", cycle_count, model_cycles);

    // R7: frozen while done
    repeat (40) @(negedge clk);
    chk("R7 done holds", done, 1);
    chk("R7 prime_count frozen", prime_count, model_primes);
    chk("R6 cycle_count frozen", cycle_count, model_cycles);

    // R4 / R2 / R10 scoreboard peeks
    peek(3);    // value 9: cleared
    peek(4);    // value 11: kept
    peek(0);    // value 3: kept
    peek(DEPTH - 1);
    for (int i = 5; i < 40; i++) peek(i);
    for (int i = 40; i < DEPTH; i += 61) peek(i);
    @(negedge clk);
    @(negedge clk);
    chk("R4 model entry 3 cleared", model_flag[3], 0);
    chk("R2 model entry 4 kept", model_flag[4], 1);

    // R9: restart from done
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 done cleared on start", done, 0);
    chk("R9 prime_count cleared", prime_count, 0);
    chk("R9 cycle_count cleared", cycle_count, 0);
    @(negedge clk);
    chk("R6 cycle_count first step", cycle_count, 1);

    // R8: start pulses during fill and sweep are ignored
    repeat (200) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2000) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;

    wait_done(ok);
    chk("R9 second run completes", ok, 1);
    if (!ok) finish_run();
    chk("R8 prime count unaffected", prime_count, model_primes);
    chk("R8 cycle count unaffected", cycle_count, model_cycles);

    peek(3);
    peek(4);
    peek(12);   // value 27: cleared
    peek(14);   // value 31: kept
    @(negedge clk);
    @(negedge clk);

    finish_run();
  end

endmodule